// File: doc/BRIEF.md
# Interrupt-to-Message Bridge

This block lives in the I/O subsystem and converts wired interrupt lines into posted single-word memory writes. Every line has its own small register group on a word-addressed slave bus. The group holds an enable bit, a 64-bit destination address split into a low word and a high word, and a read-only status word. The destination address is normally a mailbox register inside a remote interrupt controller.

When an enabled line rises, the bridge marks that line as pending. A round-robin arbiter then picks one pending line at a time. For the picked line, a single write goes out on a request/acknowledge master port. The write carries the line number as its data word and uses the line's programmed 64-bit address. A line that rises while it is disabled is dropped and leaves no trace. The interconnect that carries the write, and the controller that receives it, sit outside this block.

Top module: `irq_msg_bridge`

## Requirements
- R1: The register for line i and register slot s sits at word address i*GRP_SPAN + s. Slot 0 is the enable (bit 0), slot 1 is the low address word, slot 2 is the high address word and slot 3 is status (bit 0). Slots 0 to 2 read back what was written. Writes to status, and to unused slots, change nothing.
- R2: After reset every register reads 0 (all lines disabled, no address, nothing pending), and m_req is low.
- R3: A rising edge on an enabled line produces exactly one write. A line that stays high produces no further writes.
- R4: A rising edge on a disabled line is ignored and not remembered: enabling the line afterwards, while it is still high, produces no write.
- R5: A write for line i drives m_addr = {high word of i, low word of i} and m_wdata = i, zero-extended.
- R6: m_req, once raised, stays high with m_addr and m_wdata stable until m_ack is sampled high. m_req is low in the cycle after that handshake.
- R7: When several lines are pending, grants go in round-robin order, starting from the line after the one granted last. After reset, line 0 has top priority.
- R8: The status bit of a line reads 1 from the cycle after its rising edge until the handshake of its write, and reads 0 afterwards.
- R9: A new rising edge on a line whose write is already on the master port produces a second write after the first one completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt lines, rising-edge sensitive |
| s_sel | input | 1 | Slave access strobe |
| s_wr | input | 1 | Slave write (1) or read (0) |
| s_addr | input | AW | Slave word address |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data, combinational from s_addr |
| m_req | output | 1 | Master write request |
| m_addr | output | 64 | Master write address |
| m_wdata | output | 32 | Master write data (line number) |
| m_ack | input | 1 | Master write acknowledge |

## Verification
The bench builds the bridge with N_SRC = 4, GRP_SPAN = 4 and the round-robin variant. With only four lines, the grant pointer wraps past the last line within one burst, so the wrap-around order can be checked. Every register group is also small enough to read back completely. A longer acknowledge delay keeps a write on the port long enough to re-fire the same line while that write is in flight, which is the case R9 covers.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
   localparam int WORD_W  = 32;
   localparam int TADDR_W = 64;
   // register slot numbers inside one line's group
   localparam int SLOT_EN   = 0;
   localparam int SLOT_LO   = 1;
   localparam int SLOT_HI   = 2;
   localparam int SLOT_STAT = 3;
   localparam int SLOTS_USED = 4;
   typedef logic [WORD_W-1:0]  word_t;
   typedef logic [TADDR_W-1:0] taddr_t;
endpackage

// File: rtl/irqb_regs.sv
module irqb_regs
   import irqb_pkg::*;
#(
   parameter int N_SRC    = 8,
   parameter int GRP_SPAN = 4,
   parameter int AW       = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   s_sel,
   input  logic                   s_wr,
   input  logic [AW-1:0]          s_addr,
   input  word_t                  s_wdata,
   output word_t                  s_rdata,
   input  logic [N_SRC-1:0]       stat_i,
   output logic [N_SRC-1:0]       en_o,
   output logic [N_SRC-1:0][WORD_W-1:0] lo_o,
   output logic [N_SRC-1:0][WORD_W-1:0] hi_o
);
   localparam int OFF_W = $clog2(GRP_SPAN);
   localparam int GRP_W = (AW > OFF_W) ? AW - OFF_W : 1;

   logic [OFF_W-1:0] slot;
   logic [GRP_W-1:0] grp;
   logic             grp_ok;

   assign slot   = s_addr[OFF_W-1:0];
   assign grp    = GRP_W'(s_addr >> OFF_W);
   assign grp_ok = (int'(grp) < N_SRC);

   for (genvar i = 0; i < N_SRC; i++) begin : g_grp
      logic hit;
      assign hit = s_sel && s_wr && grp_ok && (int'(grp) == i);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_o[i] <= 1'b0;
            lo_o[i] <= '0;
            hi_o[i] <= '0;
         end else if (hit) begin
            if (int'(slot) == SLOT_EN) en_o[i] <= s_wdata[0];
            if (int'(slot) == SLOT_LO) lo_o[i] <= s_wdata;
            if (int'(slot) == SLOT_HI) hi_o[i] <= s_wdata;
         end
      end
   end

   always_comb begin
      s_rdata = '0;
      if (s_sel && !s_wr && grp_ok) begin
         for (int i = 0; i < N_SRC; i++) begin
            if (int'(grp) == i) begin
               case (int'(slot))
                  SLOT_EN:   s_rdata = {{(WORD_W-1){1'b0}}, en_o[i]};
                  SLOT_LO:   s_rdata = lo_o[i];
                  SLOT_HI:   s_rdata = hi_o[i];
                  SLOT_STAT: s_rdata = {{(WORD_W-1){1'b0}}, stat_i[i]};
                  default:   s_rdata = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/irqb_edge.sv
module irqb_edge #(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic             take_i,
   input  logic [IDX_W-1:0] take_idx_i,
   output logic [N_SRC-1:0] pend_o
);
   logic [N_SRC-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= irq_i;
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_line
      logic rise, drop;
      assign rise = irq_i[i] && !prev_q[i] && en_i[i];
      assign drop = take_i && (int'(take_idx_i) == i);
      always_ff @(posedge clk) begin
         if (!rst_n) pend_o[i] <= 1'b0;
         else        pend_o[i] <= (pend_o[i] && !drop) || rise;
      end
   end
endmodule

// File: rtl/irqb_arb.sv
module irqb_arb #(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] pend_i,
   input  logic             take_i,
   output logic             avail_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [IDX_W-1:0] last;

   if (ROUND_ROBIN) begin : g_rr
      logic [IDX_W-1:0] last_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      last_q <= IDX_W'(N_SRC-1);
         else if (take_i) last_q <= idx_o;
      end
      assign last = last_q;
   end else begin : g_fixed
      assign last = IDX_W'(N_SRC-1);
   end

   always_comb begin
      avail_o = 1'b0;
      idx_o   = '0;
      for (int k = 1; k <= N_SRC; k++) begin
         int j;
         j = int'(last) + k;
         if (j >= N_SRC) j = j - N_SRC;
         if (!avail_o && pend_i[j]) begin
            avail_o = 1'b1;
            idx_o   = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/irqb_master.sv
module irqb_master
   import irqb_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             avail_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [N_SRC-1:0][WORD_W-1:0] lo_i,
   input  logic [N_SRC-1:0][WORD_W-1:0] hi_i,
   output logic             take_o,
   output logic [N_SRC-1:0] fly_o,
   output logic             m_req,
   output taddr_t           m_addr,
   output word_t            m_wdata,
   input  logic             m_ack
);
   logic             busy_q;
   logic [IDX_W-1:0] cur_q;

   assign take_o = !busy_q && avail_i;
   assign m_req  = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_q   <= '0;
         m_addr  <= '0;
         m_wdata <= '0;
      end else if (take_o) begin
         busy_q  <= 1'b1;
         cur_q   <= idx_i;
         m_addr  <= {hi_i[idx_i], lo_i[idx_i]};
         m_wdata <= WORD_W'(idx_i);
      end else if (busy_q && m_ack) begin
         busy_q <= 1'b0;
      end
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_fly
      assign fly_o[i] = busy_q && (int'(cur_q) == i);
   end
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
   import irqb_pkg::*;
#(
   parameter int N_SRC       = 8,
   parameter int GRP_SPAN    = 4,
   parameter bit ROUND_ROBIN = 1'b1,
   parameter int AW          = $clog2(N_SRC * GRP_SPAN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic             s_sel,
   input  logic             s_wr,
   input  logic [AW-1:0]    s_addr,
   input  logic [31:0]      s_wdata,
   output logic [31:0]      s_rdata,
   output logic             m_req,
   output logic [63:0]      m_addr,
   output logic [31:0]      m_wdata,
   input  logic             m_ack
);
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   initial begin
      assert (N_SRC >= 2 && N_SRC <= 256)
         else $error("N_SRC out of range");
      assert (GRP_SPAN >= SLOTS_USED && (GRP_SPAN & (GRP_SPAN - 1)) == 0)
         else $error("GRP_SPAN must be a power of two of at least four");
      assert (AW >= $clog2(N_SRC * GRP_SPAN))
         else $error("AW too narrow for the register map");
   end

   logic [N_SRC-1:0]              en, pend, fly, stat;
   logic [N_SRC-1:0][WORD_W-1:0]  lo, hi;
   logic                          avail, take;
   logic [IDX_W-1:0]              idx;

   assign stat = pend | fly;

   irqb_regs #(.N_SRC(N_SRC), .GRP_SPAN(GRP_SPAN), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .s_sel(s_sel), .s_wr(s_wr), .s_addr(s_addr),
      .s_wdata(s_wdata), .s_rdata(s_rdata), .stat_i(stat),
      .en_o(en), .lo_o(lo), .hi_o(hi));

   irqb_edge #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .en_i(en),
      .take_i(take), .take_idx_i(idx), .pend_o(pend));

   irqb_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .take_i(take),
      .avail_o(avail), .idx_o(idx));

   irqb_master #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_mst (
      .clk(clk), .rst_n(rst_n), .avail_i(avail), .idx_i(idx),
      .lo_i(lo), .hi_i(hi), .take_o(take), .fly_o(fly),
      .m_req(m_req), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack));
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
   parameter int N_SRC = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             m_req,
   input logic             m_ack,
   input logic [63:0]      m_addr,
   input logic [31:0]      m_wdata,
   input logic [N_SRC-1:0] pend,
   input logic [N_SRC-1:0] en,
   input logic [N_SRC-1:0] stat
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_wdata))); // R6
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req && m_ack) |=> !m_req); // R6
   AST_MASKED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(en)) == '0)); // R4
   AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> (m_wdata < 32'(N_SRC))); // R5
   AST_STAT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      m_req |-> stat[m_wdata[$clog2(N_SRC)-1:0]]); // R8
endmodule

bind irq_msg_bridge irqb_checker #(.N_SRC(N_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_ack(m_ack), .m_addr(m_addr),
   .m_wdata(m_wdata), .pend(pend), .en(en), .stat(stat));

// File: tb/tb_irq_msg_bridge.sv
module tb_irq_msg_bridge;
   localparam int N  = 4;
   localparam int SP = 4;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic s_sel = 0, s_wr = 0;
   logic [AW-1:0] s_addr = '0;
   logic [31:0] s_wdata = '0, s_rdata;
   logic m_req, m_ack = 1'b0;
   logic [63:0] m_addr;
   logic [31:0] m_wdata;

   int total = 0, bad = 0;
   int ack_dly = 2;
   int writes_seen = 0;
   logic [95:0] expq[$];

   always #4 clk = ~clk;

   irq_msg_bridge #(.N_SRC(N), .GRP_SPAN(SP), .ROUND_ROBIN(1'b1), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .s_sel(s_sel), .s_wr(s_wr),
      .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .m_req(m_req),
      .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack));

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp_v);
      end
   endtask

   function automatic logic [31:0] lo_of(int i); return 32'h1000_0000 + 32'(i * 16); endfunction
   function automatic logic [31:0] hi_of(int i); return 32'h0000_00A0 + 32'(i); endfunction

   task automatic expect_write(int i);
      expq.push_back({hi_of(i), lo_of(i), 32'(i)});
   endtask

   task automatic bus_wr(int a, logic [31:0] d);
      @(negedge clk);
      s_sel = 1; s_wr = 1; s_addr = AW'(a); s_wdata = d;
      @(negedge clk);
      s_sel = 0; s_wr = 0;
   endtask

   task automatic bus_rd(int a, output logic [31:0] d);
      @(negedge clk);
      s_sel = 1; s_wr = 0; s_addr = AW'(a);
      #1 d = s_rdata;
      s_sel = 0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_drain;
      int guard = 0;
      while ((expq.size() != 0 || m_req) && guard < 500) begin
         @(negedge clk);
         guard++;
      end
      idle(6);
   endtask

   // monitor: pops expected writes and performs the acknowledge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && m_req) begin
            logic [63:0] a0;
            logic [31:0] d0;
            writes_seen++;
            a0 = m_addr; d0 = m_wdata;
            if (expq.size() == 0) begin
               chk("R3 unexpected write", {32'h0, d0}, 64'hFFFF_FFFF);
            end else begin
               logic [95:0] e;
               e = expq.pop_front();
               chk("R5 addr", a0, e[95:32]);
               chk("R7 order/R5 data", {32'h0, d0}, {32'h0, e[31:0]});
            end
            for (int k = 0; k < ack_dly; k++) begin
               @(negedge clk);
               chk("R6 held", {63'h0, m_req}, 64'h1);
               chk("R6 stable", m_addr ^ {32'h0, m_wdata}, a0 ^ {32'h0, d0});
            end
            m_ack = 1'b1;
            @(negedge clk);
            m_ack = 1'b0;
            chk("R6 drop", {63'h0, m_req}, 64'h0);
         end
      end
   end

   // watchdog
   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R2 reset state
      chk("R2 req", {63'h0, m_req}, 64'h0);
      for (int i = 0; i < N * SP; i++) begin
         bus_rd(i, r);
         chk("R2 reg", {32'h0, r}, 64'h0);
      end
      // R1 program and read back
      for (int i = 0; i < N; i++) begin
         bus_wr(i * SP + 1, lo_of(i));
         bus_wr(i * SP + 2, hi_of(i));
      end
      for (int i = 0; i < N; i++) begin
         bus_rd(i * SP + 1, r); chk("R1 lo", {32'h0, r}, {32'h0, lo_of(i)});
         bus_rd(i * SP + 2, r); chk("R1 hi", {32'h0, r}, {32'h0, hi_of(i)});
      end
      bus_wr(2 * SP + 3, 32'h1);
      bus_rd(2 * SP + 3, r); chk("R1 status not writable", {32'h0, r}, 64'h0);
      bus_wr(3 * SP + 0, 32'hFFFF_FFFF);
      bus_rd(3 * SP + 0, r); chk("R1 enable bit0 only", {32'h0, r}, 64'h1);
      bus_wr(3 * SP + 0, 32'h0);
      // R4 masked rise ignored and forgotten
      @(negedge clk) irq_in[1] = 1'b1;
      idle(4);
      bus_rd(1 * SP + 3, r); chk("R4 status", {32'h0, r}, 64'h0);
      bus_wr(1 * SP + 0, 32'h1);
      idle(10);
      chk("R4 no write", 64'(writes_seen), 64'h0);
      @(negedge clk) irq_in[1] = 1'b0;
      for (int i = 0; i < N; i++) bus_wr(i * SP + 0, 32'h1);
      idle(3);
      chk("R4 no write after enable", 64'(writes_seen), 64'h0);
      // R3/R5/R8 single line, level held high
      ack_dly = 5;
      expect_write(2);
      @(negedge clk) irq_in[2] = 1'b1;
      bus_rd(2 * SP + 3, r); chk("R8 status pending", {32'h0, r}, 64'h1);
      wait_drain();
      bus_rd(2 * SP + 3, r); chk("R8 status cleared", {32'h0, r}, 64'h0);
      idle(10);
      chk("R3 one write for held level", 64'(writes_seen), 64'h1);
      @(negedge clk) irq_in = '0;
      // R7 round robin: last grant was 2
      ack_dly = 1;
      expect_write(3); expect_write(0); expect_write(1);
      @(negedge clk) irq_in = 4'b1011;
      wait_drain();
      @(negedge clk) irq_in = '0;
      expect_write(2); expect_write(3); expect_write(0); expect_write(1);
      @(negedge clk) irq_in = 4'b1111;
      wait_drain();
      @(negedge clk) irq_in = '0;
      chk("R7 count", 64'(writes_seen), 64'd8);
      // R9 re-fire during flight
      ack_dly = 8;
      expect_write(3); expect_write(3);
      @(negedge clk) irq_in[3] = 1'b1;
      while (!m_req) @(negedge clk);
      @(negedge clk) irq_in[3] = 1'b0;
      @(negedge clk) irq_in[3] = 1'b1;
      bus_rd(3 * SP + 3, r); chk("R8 status in flight", {32'h0, r}, 64'h1);
      wait_drain();
      chk("R9 second write", 64'(writes_seen), 64'd10);
      chk("R3 queue empty", 64'(expq.size()), 64'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule